// File: doc/BRIEF.md
# Sensor Grid Path Activation Sequencer

This block drives the launch side of a delay-sensing grid. The grid has `ROWS` rows and `COLS` columns of inverters. Each column is one vertical chain. Each row is one horizontal chain, built through `COLS-1` two-input multiplexers. A single one-hot token walks across a span of `max(ROWS,COLS)` positions. At each step it enables one row-launch flop and one column-launch flop, so one horizontal chain and one vertical chain receive the new drive level together. Token positions beyond the shorter dimension leave that side idle.

The shared drive level is held for one full pass of the token and then inverts. This exercises both rising and falling delays of every chain. Once both polarities have been applied, the multiplexer select word advances. Every row receives the same select word, so across a sweep each row takes all `2^(COLS-1)` configurations. Each launch also carries a path tag, which a downstream recorder uses to label the delay it measures. A one-cycle done flag marks the last launch of a sweep. The sweep then starts again from the first step. A run input holds the whole sequence when low.

Top module: `sgs_sequencer`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), all outputs go to zero. The first launch after reset is step 0 with drive level 0 and select word 0.
- R2: On a launch at step k, `row_en` equals `1<<k` when k < ROWS and is zero otherwise. It is never more than one-hot.
- R3: On a launch at step k, `col_en` equals `1<<k` when k < COLS and is zero otherwise. It is never more than one-hot.
- R4: Each launch uses the step after that of the previous launch. After step max(ROWS,COLS)-1 the step returns to 0.
- R5: `drive_level` stays constant for max(ROWS,COLS) consecutive launches and inverts after each full pass.
- R6: The select word increments after a pass at level 1, that is after every 2·max(ROWS,COLS) launches. After the all-ones value it wraps to 0.
- R7: `mux_sel` holds the current select word once per row. Row r uses bits `[r*(COLS-1) +: COLS-1]`. Bit b of a row's word drives that row's multiplexer b.
- R8: `path_tag` is laid out, from LSB upward, as follows: bit 0 is the drive level, then the column step index (IW bits), then the row step index (IW bits), then the select word (COLS-1 bits). IW is clog2(max(ROWS,COLS)). Both step fields carry the step k.
- R9: `sweep_done` is high for exactly the one cycle of the launch at select word all-ones, level 1 and step max(ROWS,COLS)-1.
- R10: A cycle whose clock edge samples `run` low produces no launch. Both enables and `sweep_done` are zero, the step, level and select word are held, and the next launch continues from the held step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Allows advancement; low holds the sequence |
| row_en | output | ROWS | One-hot launch enables for the horizontal chains |
| col_en | output | COLS | One-hot launch enables for the vertical chains |
| drive_level | output | 1 | Shared level launched into the enabled chains |
| mux_sel | output | ROWS*(COLS-1) | Multiplexer select word repeated for each row |
| path_tag | output | COLS+2*IW | {select, row step, column step, level} label of the launch |
| sweep_done | output | 1 | One-cycle flag on the last launch of a sweep |

## Verification
Some properties are checked by assertions on every cycle:
- both enables stay at most one-hot;
- each enable matches the step carried in the tag;
- a cycle without run produces no launch;
- consecutive launches step forward by one;
- the drive level holds within a pass;
- the done flag appears only on the final tag.

Other behaviour can only be shown by the bench's scenarios against its step-by-step model. This covers the select word advancing only after both polarities, its wrap to zero, resumption after pauses of varying length, and reset in mid-sweep. It also covers exactly two done pulses in two uninterrupted sweeps.

// File: rtl/sgs_pkg.sv
// Shared helpers for the sensor grid sequencer: dimension arithmetic used
// by every module so that widths are derived in one place.
package sgs_pkg;

    // Larger of the two grid dimensions: the token span.
    function automatic int span_of(input int rows, input int cols);
        return (rows > cols) ? rows : cols;
    endfunction

    // Index width for a count, at least one bit.
    function automatic int idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/sgs_token.sv
// One-hot token ring of SPAN positions with its binary step index.
// Assumes SPAN >= 1; the token rests at position 0 after reset and
// rotates by one position on every cycle that adv is high.
module sgs_token #(
    parameter int SPAN = 4,
    localparam int IW  = sgs_pkg::idx_w(SPAN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [SPAN-1:0] tok,
    output logic [IW-1:0]   step,
    output logic            wrap
);

    // Rotate the token one position per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok <= SPAN'(1);
        end else if (adv) begin
            if (SPAN == 1) tok <= tok;
            else           tok <= {tok[SPAN-2:0], tok[SPAN-1]};
        end
    end

    // Encode the token position as a binary step index.
    always_comb begin
        step = '0;
        for (int i = 0; i < SPAN; i++) begin
            if (tok[i]) step = step | IW'(i);
        end
    end

    // Mark the last position of a pass.
    assign wrap = tok[SPAN-1];

endmodule

// File: rtl/sgs_pattern.sv
// Drive-level and multiplexer-select state. The level inverts at each pass
// end; the select word steps after the level-1 pass, wrapping naturally.
// Assumes pass_end is only meaningful together with adv.
module sgs_pattern #(
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            pass_end,
    output logic            level,
    output logic [SELW-1:0] sel,
    output logic            last_pat
);

    // Advance level and select word at the end of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            sel   <= '0;
        end else if (adv && pass_end) begin
            level <= ~level;
            if (level) sel <= sel + SELW'(1);
        end
    end

    // Final pattern of a sweep: level 1 with the all-ones select word.
    assign last_pat = level & (&sel);

endmodule

// File: rtl/sgs_sequencer.sv
// Launch sequencer for a ROWS x COLS inverter-chain sensing grid.
// Each cycle with run high registers one launch (row enable, column enable,
// level, select words, tag) from the current state and advances the state.
// Assumes COLS >= 2 so that at least one multiplexer exists per row.
module sgs_sequencer #(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    localparam int SPAN = sgs_pkg::span_of(ROWS, COLS),
    localparam int IW   = sgs_pkg::idx_w(SPAN),
    localparam int SELW = COLS - 1,
    localparam int TW   = SELW + 2*IW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    output logic [ROWS-1:0]      row_en,
    output logic [COLS-1:0]      col_en,
    output logic                 drive_level,
    output logic [ROWS*SELW-1:0] mux_sel,
    output logic [TW-1:0]        path_tag,
    output logic                 sweep_done
);

    logic [SPAN-1:0]      tok;
    logic [IW-1:0]        step;
    logic                 wrap;
    logic                 level;
    logic [SELW-1:0]      sel;
    logic                 last_pat;
    logic [ROWS*SELW-1:0] sel_rep;

    sgs_token #(.SPAN(SPAN)) u_token (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .tok   (tok),
        .step  (step),
        .wrap  (wrap)
    );

    sgs_pattern #(.SELW(SELW)) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (run),
        .pass_end (wrap),
        .level    (level),
        .sel      (sel),
        .last_pat (last_pat)
    );

    // Replicate the select word across every row's multiplexer group.
    for (genvar r = 0; r < ROWS; r++) begin : g_row_sel
        assign sel_rep[r*SELW +: SELW] = sel;
    end

    // Launch enables: held low when idle, otherwise the token slice.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            row_en     <= '0;
            col_en     <= '0;
            sweep_done <= 1'b0;
        end else begin
            row_en     <= tok[ROWS-1:0];
            col_en     <= tok[COLS-1:0];
            sweep_done <= wrap & last_pat;
        end
    end

    // Level, select words and tag: updated per launch, held while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_level <= 1'b0;
            mux_sel     <= '0;
            path_tag    <= '0;
        end else if (run) begin
            drive_level <= level;
            mux_sel     <= sel_rep;
            path_tag    <= {sel, step, step, level};
        end
    end

endmodule

// File: rtl/sgs_checker.sv
// Cycle properties of the sequencer outputs, bound to every instance.
// Assumes the port naming of sgs_sequencer.
module sgs_checker #(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    localparam int SPAN = sgs_pkg::span_of(ROWS, COLS),
    localparam int IW   = sgs_pkg::idx_w(SPAN),
    localparam int SELW = COLS - 1,
    localparam int TW   = SELW + 2*IW + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic [ROWS-1:0]      row_en,
    input logic [COLS-1:0]      col_en,
    input logic                 drive_level,
    input logic [ROWS*SELW-1:0] mux_sel,
    input logic [TW-1:0]        path_tag,
    input logic                 sweep_done
);

    logic [IW-1:0]   row_f;
    logic [IW-1:0]   col_f;
    logic [SELW-1:0] sel_f;
    logic            launch;

    assign col_f  = path_tag[IW:1];
    assign row_f  = path_tag[2*IW:IW+1];
    assign sel_f  = path_tag[TW-1 -: SELW];
    assign launch = (|row_en) | (|col_en);

    assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en));

    assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_en));

    assert_row_matches_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_en) |-> (row_en == (ROWS'(1) << row_f)));

    assert_col_matches_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|col_en) |-> (col_en == (COLS'(1) << col_f)));

    assert_step_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && $past(launch)) |->
            (row_f == (($past(row_f) == IW'(SPAN-1)) ? '0 : $past(row_f) + IW'(1))));

    assert_level_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && $past(launch) && row_f != '0) |-> $stable(drive_level));

    assert_done_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (launch && path_tag[0] && (&sel_f) && row_f == IW'(SPAN-1)));

    assert_idle_no_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (!launch && !sweep_done));

endmodule

bind sgs_sequencer sgs_checker #(.ROWS(ROWS), .COLS(COLS)) u_sgs_checker (.*);

// File: tb/sgs_sequencer_test.sv
// Self-checking bench: a behavioural step model compared on every clock.
module sgs_sequencer_test;

    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int SPAN = (ROWS > COLS) ? ROWS : COLS;
    localparam int IW   = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam int SELW = COLS - 1;
    localparam int NSEL = 1 << SELW;
    localparam int TW   = SELW + 2*IW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 run = 1'b0;
    logic [ROWS-1:0]      row_en;
    logic [COLS-1:0]      col_en;
    logic                 drive_level;
    logic [ROWS*SELW-1:0] mux_sel;
    logic [TW-1:0]        path_tag;
    logic                 sweep_done;

    int checks = 0;
    int fails  = 0;
    int done_seen = 0;

    // Model state
    int k = 0, p = 0, s = 0;
    logic [ROWS-1:0]      e_row = '0;
    logic [COLS-1:0]      e_col = '0;
    logic                 e_lvl = 1'b0;
    logic [ROWS*SELW-1:0] e_mux = '0;
    logic [TW-1:0]        e_tag = '0;
    logic                 e_done = 1'b0;

    sgs_sequencer #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .row_en(row_en), .col_en(col_en), .drive_level(drive_level),
        .mux_sel(mux_sel), .path_tag(path_tag), .sweep_done(sweep_done)
    );

    always #2 clk = ~clk;

    // Behavioural model of one launch per run cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; p = 0; s = 0;
            e_row = '0; e_col = '0; e_lvl = 1'b0; e_mux = '0; e_tag = '0; e_done = 1'b0;
        end else if (run) begin
            e_row  = (k < ROWS) ? ROWS'(1) << k : '0;
            e_col  = (k < COLS) ? COLS'(1) << k : '0;
            e_lvl  = p[0];
            for (int r = 0; r < ROWS; r++) e_mux[r*SELW +: SELW] = SELW'(s);
            e_tag  = {SELW'(s), IW'(k), IW'(k), p[0]};
            e_done = (k == SPAN-1) && (p == 1) && (s == NSEL-1);
            k = k + 1;
            if (k == SPAN) begin
                k = 0;
                if (p == 1) s = (s + 1) % NSEL;
                p = 1 - p;
            end
        end else begin
            e_row = '0; e_col = '0; e_done = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(row_en == e_row, "R2 row_en", 64'(row_en), 64'(e_row));
        check(col_en == e_col, "R3 col_en", 64'(col_en), 64'(e_col));
        check(drive_level == e_lvl, "R5 drive_level", 64'(drive_level), 64'(e_lvl));
        check(mux_sel == e_mux, "R6/R7 mux_sel", 64'(mux_sel), 64'(e_mux));
        check(path_tag == e_tag, "R4/R8 path_tag", 64'(path_tag), 64'(e_tag));
        check(sweep_done == e_done, "R9/R10 sweep_done", 64'(sweep_done), 64'(e_done));
        if (sweep_done) done_seen++;
    endtask

    task automatic cycles(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            case (mode)
                0: run = 1'b1;
                1: run = 1'b0;
                default: run = ($urandom % 3) != 0;
            endcase
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(row_en == 0 && col_en == 0 && path_tag == 0 && mux_sel == 0
              && !drive_level && !sweep_done, "R1 reset outputs", 64'(path_tag), 64'd0);
        rst_n = 1'b1;
        run = 1'b1;
        // R9: two uninterrupted sweeps give exactly two done pulses
        done_seen = 0;
        cycles(2 * SPAN * 2 * NSEL, 0);
        @(negedge clk);
        compare_all();
        check(done_seen == 2, "R9 done count", 64'(done_seen), 64'd2);
        // R10: pause, then resume
        run = 1'b0;
        cycles(5, 1);
        run = 1'b1;
        cycles(20, 0);
        // mixed run pattern
        cycles(400, 2);
        // R1: reset in mid-sweep, then first launch is step 0
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b1;
        @(negedge clk);
        check(row_en == 0 && path_tag == 0, "R1 mid-run reset", 64'(path_tag), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(row_en == ROWS'(1) && path_tag == 0, "R1 first launch", 64'(path_tag), 64'd0);
        compare_all();
        cycles(200, 2);
        cycles(100, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule